// File: doc/BRIEF.md
# I2C Transfer Status Flag Unit

This block keeps the four per-transfer status flags of a two-wire serial controller: a missing-acknowledge flag, a bus-error flag, a data-ready flag and a stop-after-slave-transfer flag. A bit-level engine feeds it single-cycle event strobes: the acknowledge sample with its level, start and stop detection, and arbitration loss. It also feeds two level signals, the current bit position inside a byte and the address-match state. The CPU side supplies strobes for a status write and for data-register reads and writes, the transfer direction and the pending start request.

Every flag is a register. A flag changes on the clock edge after the event that moves it, and a hardware event outranks a software clear. A low module enable wipes every flag on the next edge. One interrupt request is the OR of all four flags, gated by an interrupt-enable input.

Top module: `i2c_xfer_flags`

## Requirements
- R1: When `ack_stb` is high with `ack_high` = 1, `flag_nack` is 1 after the next edge, and that strobe does not set `flag_ready`.
- R2: A status write (`csr_wr`) with `csr_wdata` bit 0 = 1 clears `flag_nack`, bit 1 = 1 clears `flag_berr` and bit 3 = 1 clears `flag_sstop`. A 0 in any of those bits leaves that flag unchanged.
- R3: A hardware set event and a write-1 clear of the same flag in one cycle leave the flag set.
- R4: Reset, or `mod_en` low at an edge, makes all four flags 0 after that edge. No event sets a flag while `mod_en` is low.
- R5: `bit_pos` encodes 0 = no byte in progress, 1..8 = data bits and 9 = the acknowledge bit. A `start_det` or `stop_det` while `bit_pos` is in 2..9 sets `flag_berr`. The same strobe at positions 0 or 1 does not set it.
- R6: `arb_lost` sets `flag_berr`.
- R7: `ack_stb` with `ack_high` = 0 sets `flag_ready`. With `xmit` = 0 (receive), `data_rd` clears it and `data_wr` has no effect. With `xmit` = 1 (transmit), `data_wr` clears it and `data_rd` has no effect.
- R8: In receive, a `data_rd` while `start_req` = 1 leaves `flag_ready` set.
- R9: `stop_det` sets `flag_sstop` if `own_match` or `gc_match` is high in that cycle, or was high in any cycle since the last start or stop. Otherwise a stop leaves the flag unchanged.
- R10: `irq` is 1 exactly when `irq_en` = 1 and at least one of the four flags is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_en | input | 1 | Module enable; low clears all flags |
| irq_en | input | 1 | Interrupt enable |
| ack_stb | input | 1 | Acknowledge bit sampled this cycle |
| ack_high | input | 1 | Sampled acknowledge level (1 = not acknowledged) |
| bit_pos | input | BIT_POS_W (4) | Bit position in byte: 0 idle, 1..8 data, 9 acknowledge |
| start_det | input | 1 | Start or repeated start detected |
| stop_det | input | 1 | Stop detected |
| arb_lost | input | 1 | Arbitration problem detected |
| own_match | input | 1 | Own-address match active |
| gc_match | input | 1 | General-call match active |
| xmit | input | 1 | Direction: 1 transmit, 0 receive |
| start_req | input | 1 | Start-request control bit |
| csr_wr | input | 1 | Status register write strobe |
| csr_wdata | input | CSR_W (8) | Status write data |
| data_rd | input | 1 | Data register read strobe |
| data_wr | input | 1 | Data register write strobe |
| flag_nack | output | 1 | Missing-acknowledge flag |
| flag_berr | output | 1 | Bus-error flag |
| flag_ready | output | 1 | Data register waiting to be loaded or unloaded |
| flag_sstop | output | 1 | Stop seen after a slave transfer |
| irq | output | 1 | Combined interrupt request |

## Verification
Each flag is a single register that the ports see directly. A wrong set, clear or priority decision therefore shows on a flag output on the edge right after the stimulus, and it persists until a later event hides it. The only hidden state is the remembered slave-transfer indication. If that indication is wrong, nothing shows until the next stop, when `flag_sstop` rises or stays low. The bench runs a per-cycle reference model on random traffic so that both kinds of error are caught on the cycle where they first show at the ports.

// File: rtl/i2c_flag_pkg.sv
package i2c_flag_pkg;

  // Indices of the write-1-to-clear flags inside the cell array
  localparam int unsigned NUM_W1C   = 3;
  localparam int unsigned IDX_NACK  = 0;
  localparam int unsigned IDX_BERR  = 1;
  localparam int unsigned IDX_SSTOP = 2;

  // Positions of the clear bits in the status write word
  localparam int unsigned CSR_NACK_POS  = 0;
  localparam int unsigned CSR_BERR_POS  = 1;
  localparam int unsigned CSR_READY_POS = 2;
  localparam int unsigned CSR_SSTOP_POS = 3;

  typedef struct packed {
    logic nack_set;
    logic berr_set;
    logic sstop_set;
    logic ready_set;
  } flag_evt_t;

  function automatic int unsigned w1c_csr_pos(int unsigned idx);
    case (idx)
      IDX_NACK: return CSR_NACK_POS;
      IDX_BERR: return CSR_BERR_POS;
      default:  return CSR_SSTOP_POS;
    endcase
  endfunction

endpackage

// File: rtl/i2c_flag_events.sv
module i2c_flag_events
  import i2c_flag_pkg::*;
#(
  parameter int unsigned BIT_POS_W = 4,
  parameter int unsigned ERR_LO    = 2,
  parameter int unsigned ERR_HI    = 9
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mod_en,
  input  logic                 ack_stb,
  input  logic                 ack_high,
  input  logic [BIT_POS_W-1:0] bit_pos,
  input  logic                 start_det,
  input  logic                 stop_det,
  input  logic                 arb_lost,
  input  logic                 own_match,
  input  logic                 gc_match,
  output flag_evt_t            evt
);

  localparam logic [BIT_POS_W-1:0] WIN_LO = BIT_POS_W'(ERR_LO);
  localparam logic [BIT_POS_W-1:0] WIN_HI = BIT_POS_W'(ERR_HI);

  logic in_window;
  logic cond_seen;
  logic match_now;
  logic slv_seen_q;
  logic slv_seen_d;
  logic slv_seen_en;

  assign in_window = (bit_pos >= WIN_LO) && (bit_pos <= WIN_HI);
  assign cond_seen = start_det | stop_det;
  assign match_now = own_match | gc_match;

  // Slave-transfer memory: set by a match, dropped by any start/stop
  always_comb begin
    slv_seen_en = 1'b0;
    slv_seen_d  = slv_seen_q;
    if (!mod_en) begin
      slv_seen_en = 1'b1;
      slv_seen_d  = 1'b0;
    end else if (cond_seen) begin
      slv_seen_en = 1'b1;
      slv_seen_d  = 1'b0;
    end else if (match_now) begin
      slv_seen_en = 1'b1;
      slv_seen_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slv_seen_q <= 1'b0;
    end else if (slv_seen_en) begin
      slv_seen_q <= slv_seen_d;
    end
  end

  always_comb begin
    evt.nack_set  = ack_stb & ack_high;
    evt.ready_set = ack_stb & ~ack_high;
    evt.berr_set  = (cond_seen & in_window) | arb_lost;
    evt.sstop_set = stop_det & (slv_seen_q | match_now);
  end

  // R9: a start or stop forgets the earlier slave transfer
  p_slv_forget_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_en && cond_seen) |=> !slv_seen_q);

  // R9: a match with no start/stop is remembered
  p_slv_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_en && match_now && !cond_seen) |=> slv_seen_q);

  // R1: the two acknowledge outcomes never coincide
  p_ack_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(evt.nack_set && evt.ready_set));

endmodule

// File: rtl/i2c_w1c_cell.sv
module i2c_w1c_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic mod_en,
  input  logic set_ev,
  input  logic clr_wr,
  output logic q
);

  logic d;
  logic en;

  // Priority: disable, hardware set, write-1 clear, hold
  always_comb begin
    en = 1'b0;
    d  = q;
    if (!mod_en) begin
      en = 1'b1;
      d  = 1'b0;
    end else if (set_ev) begin
      en = 1'b1;
      d  = 1'b1;
    end else if (clr_wr) begin
      en = 1'b1;
      d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= 1'b0;
    end else if (en) begin
      q <= d;
    end
  end

  p_set_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_en && set_ev) |=> q);

  p_w1c_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_en && clr_wr && !set_ev) |=> !q);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_en && !clr_wr && !set_ev) |=> $stable(q));

  p_disable_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !mod_en |=> !q);

endmodule

// File: rtl/i2c_ready_cell.sv
module i2c_ready_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic mod_en,
  input  logic set_ev,
  input  logic xmit,
  input  logic data_rd,
  input  logic data_wr,
  input  logic start_req,
  output logic q
);

  logic clr_ev;
  logic d;
  logic en;

  // Transmit: a load of the data register empties it.
  // Receive: an unload does, unless a start is being requested.
  assign clr_ev = xmit ? data_wr : (data_rd & ~start_req);

  always_comb begin
    en = 1'b0;
    d  = q;
    if (!mod_en) begin
      en = 1'b1;
      d  = 1'b0;
    end else if (set_ev) begin
      en = 1'b1;
      d  = 1'b1;
    end else if (clr_ev) begin
      en = 1'b1;
      d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= 1'b0;
    end else if (en) begin
      q <= d;
    end
  end

  p_rd_hold_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_en && q && !xmit && data_rd && start_req) |=> q);

  p_wrong_dir_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_en && q && xmit && data_rd && !data_wr) |=> q);

  p_disable_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !mod_en |=> !q);

endmodule

// File: rtl/i2c_xfer_flags.sv
module i2c_xfer_flags
  import i2c_flag_pkg::*;
#(
  parameter int unsigned BITS_PER_BYTE = 8,
  parameter int unsigned ERR_FIRST_BIT = 2,
  parameter int unsigned CSR_W         = 8,
  parameter int unsigned BIT_POS_W     = $clog2(BITS_PER_BYTE + 2)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mod_en,
  input  logic                 irq_en,
  input  logic                 ack_stb,
  input  logic                 ack_high,
  input  logic [BIT_POS_W-1:0] bit_pos,
  input  logic                 start_det,
  input  logic                 stop_det,
  input  logic                 arb_lost,
  input  logic                 own_match,
  input  logic                 gc_match,
  input  logic                 xmit,
  input  logic                 start_req,
  input  logic                 csr_wr,
  input  logic [CSR_W-1:0]     csr_wdata,
  input  logic                 data_rd,
  input  logic                 data_wr,
  output logic                 flag_nack,
  output logic                 flag_berr,
  output logic                 flag_ready,
  output logic                 flag_sstop,
  output logic                 irq
);

  localparam int unsigned ACK_POS = BITS_PER_BYTE + 1;

  flag_evt_t           evt;
  logic [NUM_W1C-1:0]  w1c_set;
  logic [NUM_W1C-1:0]  w1c_clr;
  logic [NUM_W1C-1:0]  w1c_q;

  i2c_flag_events #(
    .BIT_POS_W (BIT_POS_W),
    .ERR_LO    (ERR_FIRST_BIT),
    .ERR_HI    (ACK_POS)
  ) u_events (
    .clk       (clk),
    .rst_n     (rst_n),
    .mod_en    (mod_en),
    .ack_stb   (ack_stb),
    .ack_high  (ack_high),
    .bit_pos   (bit_pos),
    .start_det (start_det),
    .stop_det  (stop_det),
    .arb_lost  (arb_lost),
    .own_match (own_match),
    .gc_match  (gc_match),
    .evt       (evt)
  );

  assign w1c_set[IDX_NACK]  = evt.nack_set;
  assign w1c_set[IDX_BERR]  = evt.berr_set;
  assign w1c_set[IDX_SSTOP] = evt.sstop_set;

  for (genvar g = 0; g < NUM_W1C; g++) begin : g_w1c
    assign w1c_clr[g] = csr_wr & csr_wdata[w1c_csr_pos(g)];

    i2c_w1c_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .mod_en (mod_en),
      .set_ev (w1c_set[g]),
      .clr_wr (w1c_clr[g]),
      .q      (w1c_q[g])
    );
  end

  i2c_ready_cell u_ready (
    .clk       (clk),
    .rst_n     (rst_n),
    .mod_en    (mod_en),
    .set_ev    (evt.ready_set),
    .xmit      (xmit),
    .data_rd   (data_rd),
    .data_wr   (data_wr),
    .start_req (start_req),
    .q         (flag_ready)
  );

  assign flag_nack  = w1c_q[IDX_NACK];
  assign flag_berr  = w1c_q[IDX_BERR];
  assign flag_sstop = w1c_q[IDX_SSTOP];

  assign irq = irq_en & (flag_nack | flag_berr | flag_ready | flag_sstop);

  // R1: a refused byte never raises the ready flag
  p_nack_no_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_en && ack_stb && ack_high && !flag_ready) |=> (flag_nack && !flag_ready));

  // R6: arbitration trouble always ends with a bus error
  p_arb_berr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_en && arb_lost) |=> flag_berr);

endmodule

// File: tb/i2c_xfer_flags_tb_top.sv
module i2c_xfer_flags_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       mod_en, irq_en, ack_stb, ack_high;
  logic [3:0] bit_pos;
  logic       start_det, stop_det, arb_lost, own_match, gc_match;
  logic       xmit, start_req, csr_wr, data_rd, data_wr;
  logic [7:0] csr_wdata;
  logic       flag_nack, flag_berr, flag_ready, flag_sstop, irq;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  logic m_nack, m_berr, m_ready, m_sstop, m_slv;
  logic x_nack, x_berr, x_ready, x_sstop, x_slv;

  always #4 clk = ~clk;

  i2c_xfer_flags dut_i (
    .clk(clk), .rst_n(rst_n), .mod_en(mod_en), .irq_en(irq_en),
    .ack_stb(ack_stb), .ack_high(ack_high), .bit_pos(bit_pos),
    .start_det(start_det), .stop_det(stop_det), .arb_lost(arb_lost),
    .own_match(own_match), .gc_match(gc_match), .xmit(xmit),
    .start_req(start_req), .csr_wr(csr_wr), .csr_wdata(csr_wdata),
    .data_rd(data_rd), .data_wr(data_wr), .flag_nack(flag_nack),
    .flag_berr(flag_berr), .flag_ready(flag_ready),
    .flag_sstop(flag_sstop), .irq(irq)
  );

  task automatic check(string tag, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  function automatic logic nxt(logic en, logic cur, logic set, logic clr);
    if (!en) return 1'b0;
    if (set) return 1'b1;
    if (clr) return 1'b0;
    return cur;
  endfunction

  task automatic model_next();
    logic win, bset, sset, rclr;
    win  = (bit_pos >= 4'd2) && (bit_pos <= 4'd9);
    bset = arb_lost | ((start_det | stop_det) & win);
    sset = stop_det & (m_slv | own_match | gc_match);
    rclr = xmit ? data_wr : (data_rd & ~start_req);
    x_nack  = nxt(mod_en, m_nack,  ack_stb & ack_high, csr_wr & csr_wdata[0]);
    x_berr  = nxt(mod_en, m_berr,  bset, csr_wr & csr_wdata[1]);
    x_sstop = nxt(mod_en, m_sstop, sset, csr_wr & csr_wdata[3]);
    x_ready = nxt(mod_en, m_ready, ack_stb & ~ack_high, rclr);
    if (!mod_en || start_det || stop_det) x_slv = 1'b0;
    else x_slv = m_slv | own_match | gc_match;
  endtask

  task automatic compare_model();
    check("R1", "nack", flag_nack, m_nack);
    check("R5", "berr", flag_berr, m_berr);
    check("R7", "ready", flag_ready, m_ready);
    check("R9", "sstop", flag_sstop, m_sstop);
    check("R10", "irq", irq, irq_en & (m_nack | m_berr | m_ready | m_sstop));
  endtask

  task automatic cyc();
    model_next();
    @(posedge clk);
    #2;
    m_nack = x_nack; m_berr = x_berr; m_ready = x_ready;
    m_sstop = x_sstop; m_slv = x_slv;
    compare_model();
  endtask

  task automatic idle();
    mod_en = 1'b1; ack_stb = 1'b0; ack_high = 1'b0; bit_pos = 4'd0;
    start_det = 1'b0; stop_det = 1'b0; arb_lost = 1'b0;
    own_match = 1'b0; gc_match = 1'b0; start_req = 1'b0;
    csr_wr = 1'b0; csr_wdata = 8'h00; data_rd = 1'b0; data_wr = 1'b0;
  endtask

  task automatic clear_all();
    idle(); csr_wr = 1'b1; csr_wdata = 8'hFF; xmit = 1'b1; data_wr = 1'b1;
    cyc(); idle();
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; irq_en = 1'b1; xmit = 1'b0; idle();
    m_nack = 0; m_berr = 0; m_ready = 0; m_sstop = 0; m_slv = 0;
    ack_stb = 1'b1; arb_lost = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    check("R4", "reset nack", flag_nack, 1'b0);
    check("R4", "reset berr", flag_berr, 1'b0);
    check("R4", "reset ready", flag_ready, 1'b0);
    check("R4", "reset sstop", flag_sstop, 1'b0);
    check("R10", "reset irq", irq, 1'b0);
    idle();
    rst_n = 1'b1;
    cyc();

    // R1: refused byte
    ack_stb = 1'b1; ack_high = 1'b1; cyc(); idle();
    check("R1", "nack set", flag_nack, 1'b1);
    check("R1", "ready not set", flag_ready, 1'b0);
    // R2: write 0 ignored, write 1 clears
    csr_wr = 1'b1; csr_wdata = 8'hF6; cyc(); idle();
    check("R2", "nack kept on 0", flag_nack, 1'b1);
    csr_wr = 1'b1; csr_wdata = 8'h01; cyc(); idle();
    check("R2", "nack cleared", flag_nack, 1'b0);
    // R3: set beats clear
    ack_stb = 1'b1; ack_high = 1'b1; csr_wr = 1'b1; csr_wdata = 8'h01; cyc(); idle();
    check("R3", "set wins", flag_nack, 1'b1);
    clear_all();
    // R5: window edges
    start_det = 1'b1; bit_pos = 4'd1; cyc(); idle();
    check("R5", "no berr at bit 1", flag_berr, 1'b0);
    stop_det = 1'b1; bit_pos = 4'd0; cyc(); idle();
    check("R5", "no berr idle", flag_berr, 1'b0);
    start_det = 1'b1; bit_pos = 4'd9; cyc(); idle();
    check("R5", "berr at ack", flag_berr, 1'b1);
    clear_all();
    stop_det = 1'b1; bit_pos = 4'd2; cyc(); idle();
    check("R5", "berr at bit 2", flag_berr, 1'b1);
    clear_all();
    // R6
    arb_lost = 1'b1; cyc(); idle();
    check("R6", "berr on arb", flag_berr, 1'b1);
    clear_all();
    // R7: receive
    xmit = 1'b0; ack_stb = 1'b1; cyc(); idle();
    check("R7", "ready set", flag_ready, 1'b1);
    data_wr = 1'b1; cyc(); idle();
    check("R7", "rx write ignored", flag_ready, 1'b1);
    data_rd = 1'b1; cyc(); idle();
    check("R7", "rx read clears", flag_ready, 1'b0);
    // R7: transmit
    xmit = 1'b1; ack_stb = 1'b1; cyc(); idle();
    data_rd = 1'b1; cyc(); idle();
    check("R7", "tx read ignored", flag_ready, 1'b1);
    data_wr = 1'b1; cyc(); idle();
    check("R7", "tx write clears", flag_ready, 1'b0);
    // R8
    xmit = 1'b0; ack_stb = 1'b1; cyc(); idle();
    start_req = 1'b1; data_rd = 1'b1; cyc(); idle();
    check("R8", "read with start req", flag_ready, 1'b1);
    data_rd = 1'b1; cyc(); idle();
    check("R8", "read after start req", flag_ready, 1'b0);
    // R9
    start_det = 1'b1; cyc(); idle();
    own_match = 1'b1; cyc(); idle();
    cyc();
    stop_det = 1'b1; cyc(); idle();
    check("R9", "sstop after match", flag_sstop, 1'b1);
    clear_all();
    start_det = 1'b1; cyc(); idle();
    stop_det = 1'b1; cyc(); idle();
    check("R9", "no sstop without match", flag_sstop, 1'b0);
    gc_match = 1'b1; stop_det = 1'b1; cyc(); idle();
    check("R9", "sstop on gc same cycle", flag_sstop, 1'b1);
    // R10
    irq_en = 1'b1; cyc();
    check("R10", "irq on", irq, 1'b1);
    irq_en = 1'b0; #1;
    check("R10", "irq gated", irq, 1'b0);
    irq_en = 1'b1;
    // R4: disable
    ack_stb = 1'b1; ack_high = 1'b1; arb_lost = 1'b1; cyc(); idle();
    mod_en = 1'b0; cyc();
    check("R4", "disable nack", flag_nack, 1'b0);
    check("R4", "disable berr", flag_berr, 1'b0);
    check("R4", "disable sstop", flag_sstop, 1'b0);
    ack_stb = 1'b1; ack_high = 1'b1; arb_lost = 1'b1; cyc();
    check("R4", "no set while off", flag_nack | flag_berr, 1'b0);
    idle(); cyc();

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      mod_en    = ($urandom_range(99) < 97);
      irq_en    = ($urandom_range(99) < 70);
      ack_stb   = ($urandom_range(99) < 20);
      ack_high  = ($urandom_range(99) < 30);
      bit_pos   = 4'($urandom_range(9));
      start_det = ($urandom_range(99) < 5);
      stop_det  = ($urandom_range(99) < 6);
      arb_lost  = ($urandom_range(99) < 3);
      own_match = ($urandom_range(99) < 8);
      gc_match  = ($urandom_range(99) < 4);
      if ($urandom_range(99) < 10) xmit = ~xmit;
      start_req = ($urandom_range(99) < 20);
      csr_wr    = ($urandom_range(99) < 15);
      csr_wdata = 8'($urandom_range(255));
      data_rd   = ($urandom_range(99) < 15);
      data_wr   = ($urandom_range(99) < 15);
      cyc();
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule